// File: doc/BRIEF.md
# SPI Write-Then-Read Transaction Engine

This block is a SPI master that performs one half-duplex command exchange with a serial memory or a similar slave. A request gives a count of command bytes to send and a count of response bytes to collect. The engine takes the command bytes from a byte stream and shifts each one out. It then shifts out zero filler bytes, one for each response byte, so that the slave can drive its answer on MISO. Bytes that arrive while the command is going out are dropped. Only the response bytes leave on the receive stream.

Chip select is a plain level. It goes low before the first clock edge of the exchange and stays low until the last byte has ended, with no gap between bytes. The serial clock runs in mode 0: it idles low, data is sampled on the rising edge, MOSI changes only while the clock is low, and each byte goes most-significant bit first. The clock high time is a parameter. Dropping `enable` abandons any exchange and returns every pin to idle.

The transmit stream uses valid/ready. The engine raises `tx_ready` only while it waits for the next command byte, and the byte moves on a clock edge where both signals are high. While `tx_valid` stays low the engine stalls with SCLK low and chip select still asserted. The receive stream has no back-pressure: each `rx_valid` pulse lasts one cycle and must be taken in that cycle.

Top module: `spi_xfer_engine`

## Requirements
- R1: A request with command length T and response length R makes exactly T+R byte slots. Each slot gives 8 rising SCLK edges.
- R2: Bytes clocked in during the first T slots are discarded. The byte clocked in during each of the next R slots appears on `rx_data` with a one-cycle `rx_valid` pulse, in slot order, with the first bit received as bit 7.
- R3: Exactly T transmit handshakes (`tx_valid` and `tx_ready` high on the same edge) occur, in stream order. Slot i<T shifts out the i-th accepted byte, and every later slot shifts out 0x00. While `tx_valid` is low the engine stalls with SCLK low.
- R4: `cs_n` falls once per request with a nonzero total, before the first SCLK rise. It rises only after the last SCLK fall and never toggles between bytes.
- R5: Mode 0 timing: SCLK is low whenever `cs_n` is high, MOSI holds its value across every SCLK rise, and bit 7 of each byte goes first.
- R6: SCLK stays high for exactly 1+SCR clock cycles per pulse. SCR is a parameter, and its default of 0 gives half the clock rate.
- R7: Receive state is flushed when a transaction starts. No `rx_valid` appears outside the response phase, and no part of an abandoned exchange is ever delivered.
- R8: While `enable` is low, `cs_n` is high, SCLK and MOSI are low, `start` is ignored, and an exchange in progress is dropped without `done`.
- R9: `start` is ignored while `busy` is high. `done` is high for exactly one cycle, the first cycle in which `cs_n` is high again after the exchange.
- R10: R=0 completes normally with no `rx_valid`. T=R=0 gives `done` without `cs_n` ever going low.
- R11: During and right after reset, `cs_n` is high and `sclk`, `busy`, `done`, `tx_ready` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Port enable; low forces the bus idle |
| start | input | 1 | Request pulse, taken when idle and enabled |
| tx_len | input | LEN_W | Command byte count T |
| rx_len | input | LEN_W | Response byte count R |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_data | input | 8 | Command byte |
| tx_valid | input | 1 | Command byte offered |
| tx_ready | output | 1 | Engine accepts a command byte |
| rx_data | output | 8 | Response byte |
| rx_valid | output | 1 | Response byte present (one cycle) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The delivery of a finished response byte and the fall of SCLK that ends that byte happen on the same clock edge. The bench checks that every response byte matches the value its slave model drove in that slot, and that the filler or command bit on MOSI is still correct at the rising edge that follows. A `start` pulse in the middle of an exchange, together with a drop of `enable` during the command phase, makes the request path and the abort path meet the shift path while it is running. The bench then checks the SCLK pulse count, the number of `done` pulses, and that nothing from the abandoned exchange reaches the receive stream.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int BYTE_W = 8;
  localparam int PH_W   = $clog2(2 * BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_END,
    ST_FIN
  } xfer_state_t;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              load_zero,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              rise,
  input  logic              fall,
  input  logic              deliver,
  input  logic              miso,
  output logic              mosi_bit,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid
);
  logic [BYTE_W-1:0] sh_q;
  logic              smp_q;
  logic [BYTE_W-1:0] rxd_q;
  logic              rxv_q;

  assign mosi_bit = sh_q[BYTE_W-1];
  assign rx_data  = rxd_q;
  assign rx_valid = rxv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      smp_q <= 1'b0;
      rxd_q <= '0;
      rxv_q <= 1'b0;
    end else if (clear) begin
      sh_q  <= '0;
      smp_q <= 1'b0;
      rxd_q <= '0;
      rxv_q <= 1'b0;
    end else begin
      rxv_q <= deliver;
      if (load)      sh_q <= load_zero ? '0 : load_byte;
      else if (fall) sh_q <= {sh_q[BYTE_W-2:0], smp_q};
      if (rise)      smp_q <= miso;
      if (deliver)   rxd_q <= {sh_q[BYTE_W-2:0], smp_q};
    end
  end

  // R3: a new byte is never loaded on the edge that ends a byte
  a_r3_load_apart: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !fall);
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             tx_valid,
  input  logic             tick,
  output logic             run,
  output logic             tx_ready,
  output logic             load,
  output logic             load_zero,
  output logic             rise,
  output logic             fall,
  output logic             deliver,
  output logic             clear,
  output logic             drive_mosi,
  output logic             sclk,
  output logic             cs_n,
  output logic             busy,
  output logic             done
);
  localparam int SLOT_W = LEN_W + 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * BYTE_W - 1);

  xfer_state_t       state_q;
  logic [SLOT_W-1:0] slot_q, tot_q;
  logic [LEN_W-1:0]  txl_q;
  logic [PH_W-1:0]   ph_q;
  logic              sclk_q;
  logic              need_tx;
  logic              in_shift;

  assign need_tx    = SLOT_W'(txl_q) > slot_q;
  assign in_shift   = (state_q == ST_SHIFT) && enable && tick;
  assign run        = enable && ((state_q == ST_SHIFT) || (state_q == ST_END));
  assign tx_ready   = enable && (state_q == ST_LOAD) && need_tx;
  assign load       = enable && (state_q == ST_LOAD) && (!need_tx || tx_valid);
  assign load_zero  = !need_tx;
  assign rise       = in_shift && !ph_q[0];
  assign fall       = in_shift && ph_q[0];
  assign deliver    = fall && (ph_q == PH_LAST) && !need_tx;
  assign clear      = enable && (state_q == ST_IDLE) && start;
  assign drive_mosi = (state_q == ST_LOAD) || (state_q == ST_SHIFT);
  assign sclk       = sclk_q;
  assign cs_n       = !((state_q == ST_LOAD) || (state_q == ST_SHIFT) || (state_q == ST_END));
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      tot_q   <= '0;
      txl_q   <= '0;
      ph_q    <= '0;
      sclk_q  <= 1'b0;
    end else if (!enable) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          txl_q   <= tx_len;
          tot_q   <= SLOT_W'(tx_len) + SLOT_W'(rx_len);
          slot_q  <= '0;
          state_q <= ((tx_len == '0) && (rx_len == '0)) ? ST_FIN : ST_LOAD;
        end
        ST_LOAD: if (load) begin
          ph_q    <= '0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          ph_q   <= ph_q + 1'b1;
          sclk_q <= !ph_q[0];
          if (ph_q == PH_LAST) begin
            slot_q  <= slot_q + 1'b1;
            state_q <= (slot_q + 1'b1 == tot_q) ? ST_END : ST_LOAD;
          end
        end
        ST_END:  if (tick) state_q <= ST_FIN;
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: chip select releases only at completion or on a port disable
  a_r4_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (done || !$past(enable)));
  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: serial clock is low whenever the slave is deselected
  a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R3: command bytes are requested only inside a selected exchange
  a_r3_ready_selected: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!cs_n && !sclk));
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int SCR   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  output logic             busy,
  output logic             done,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int HALF = 1 + SCR;
  localparam int HC_W = $clog2(HALF + 2);

  logic tick, run, load, load_zero, rise, fall, deliver, clear, drive_mosi, mosi_bit;

  spi_half_timer #(.HALF(HALF)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  spi_xfer_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .tx_len(tx_len), .rx_len(rx_len), .tx_valid(tx_valid), .tick(tick),
    .run(run), .tx_ready(tx_ready), .load(load), .load_zero(load_zero),
    .rise(rise), .fall(fall), .deliver(deliver), .clear(clear),
    .drive_mosi(drive_mosi), .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done)
  );

  spi_byte_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .load_zero(load_zero),
    .load_byte(tx_data), .rise(rise), .fall(fall), .deliver(deliver), .miso(miso),
    .mosi_bit(mosi_bit), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  assign mosi = drive_mosi && mosi_bit;

  logic [HC_W-1:0] hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hi_q <= '0;
    else if (!sclk)                   hi_q <= '0;
    else if (hi_q != HC_W'(HALF + 1)) hi_q <= hi_q + 1'b1;
  end

  // R5: data out holds across every rising serial clock edge
  a_r5_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  // R6: each high phase of the serial clock lasts 1+SCR cycles
  a_r6_high_time: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && $past(enable)) |-> (hi_q == HC_W'(HALF)));
endmodule

// File: tb/tb_spi_xfer_engine.sv
module tb_spi_xfer_engine;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;
  localparam int SCR_T = 1;
  localparam int HALF_T = 1 + SCR_T;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, start = 1'b0;
  logic [LEN_W-1:0] tx_len = '0, rx_len = '0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, miso = 1'b0;
  logic busy, done, tx_ready, rx_valid, sclk, mosi, cs_n;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mos_cap [64];
  int s_slot = 0, s_bit = 0;
  int sclk_rises = 0, cs_falls = 0, hs_cnt = 0, done_cnt = 0;
  int hi_run = 0, last_hi = 0;

  spi_xfer_engine #(.LEN_W(LEN_W), .SCR(SCR_T)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .tx_len(tx_len), .rx_len(rx_len), .busy(busy), .done(done),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] resp(input int i);
    return 8'(i * 59 + 92);
  endfunction

  function automatic logic [7:0] cmd(input int i);
    return 8'(8'hC3 + i * 29);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Slave model: drives MISO (mode 0) and captures MOSI on rising SCLK
  always @(negedge cs_n) begin
    logic [7:0] r;
    s_slot = 0; s_bit = 0; cs_falls++;
    r = resp(0);
    miso = r[7];
  end
  always @(posedge sclk) if (!cs_n) begin
    sclk_rises++;
    if (s_slot < 64) mos_cap[s_slot][7 - s_bit] = mosi;
  end
  always @(negedge sclk) if (!cs_n) begin
    logic [7:0] r;
    if (s_bit == 7) begin s_bit = 0; s_slot++; end
    else s_bit++;
    r = resp(s_slot);
    miso = r[7 - s_bit];
  end

  always @(posedge clk) if (tx_valid && tx_ready) hs_cnt++;

  // Monitor: scoreboard compare of response bytes
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (sclk) hi_run++;
    else begin
      if (hi_run > 0) last_hi = hi_run;
      hi_run = 0;
    end
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected rx byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R2 rx byte", rx_data, e);
      end
    end
  end

  task automatic run_txn(input int tl, input int rl, input int gap, input bit poke);
    int tot, cyc;
    tot = tl + rl;
    for (int i = 0; i < rl; i++) exp_q.push_back(resp(tl + i));
    for (int i = 0; i < 64; i++) mos_cap[i] = 8'h55;
    sclk_rises = 0; cs_falls = 0; hs_cnt = 0; done_cnt = 0; last_hi = 0;
    @(negedge clk);
    tx_len = LEN_W'(tl); rx_len = LEN_W'(rl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      begin
        for (int i = 0; i < tl; i++) begin
          tx_valid = 1'b1; tx_data = cmd(i);
          while (!tx_ready) @(negedge clk);
          @(negedge clk);
          tx_valid = 1'b0;
          repeat (gap) @(negedge clk);
        end
      end
      begin
        if (poke) begin
          repeat (6) @(negedge clk);
          tx_len = 8'd1; rx_len = 8'd7; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
      begin
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
      end
    join
    chk(done == 1'b1, "R9 done seen", done, 1);
    chk(cs_n == 1'b1, "R9 cs_n high with done", cs_n, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    @(negedge clk);
    chk(busy == 1'b0, "R9 idle after done", busy, 0);
    chk(done_cnt == 1, "R9 single done", done_cnt, 1);
    chk(sclk_rises == 8 * tot, "R1 sclk pulses", sclk_rises, 8 * tot);
    chk(cs_falls == (tot > 0 ? 1 : 0), "R4 cs_n falls once", cs_falls, tot > 0 ? 1 : 0);
    chk(hs_cnt == tl, "R3 handshakes", hs_cnt, tl);
    chk(exp_q.size() == 0, "R2 all response bytes delivered", exp_q.size(), 0);
    for (int i = 0; i < tot; i++) begin
      if (i < tl) chk(mos_cap[i] == cmd(i), "R3 R5 command byte on MOSI", mos_cap[i], cmd(i));
      else        chk(mos_cap[i] == 8'h00, "R3 zero filler on MOSI", mos_cap[i], 0);
    end
    if (tot > 0) chk(last_hi == HALF_T, "R6 sclk high time", last_hi, HALF_T);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1, "R11 cs_n in reset", cs_n, 1);
    chk({sclk, busy, done, tx_ready, rx_valid} == 5'b0, "R11 outputs low in reset",
        {sclk, busy, done, tx_ready, rx_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && !busy, "R11 idle after reset", {cs_n, busy}, 2);

    // R8 start ignored while disabled
    start = 1'b1; tx_len = 8'd2; rx_len = 8'd2;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && cs_n && !sclk && !mosi, "R8 disabled start ignored", {busy, cs_n, sclk, mosi}, 4);

    enable = 1'b1;
    @(negedge clk);
    run_txn(4, 2, 0, 1'b0);   // R1 R2 R3 basic
    run_txn(1, 3, 3, 1'b0);   // R3 back-pressure gaps
    run_txn(3, 0, 1, 1'b0);   // R10 zero receive length
    run_txn(0, 2, 0, 1'b0);   // R3 filler only
    run_txn(0, 0, 0, 1'b0);   // R10 zero total, no chip select
    run_txn(2, 5, 0, 1'b1);   // R9 start while busy ignored

    // R8 R7 abort mid exchange, nothing delivered
    tx_len = 8'd2; rx_len = 8'd3; start = 1'b1; tx_data = 8'hA7; tx_valid = 1'b1;
    done_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(cs_n && !sclk && !mosi && !busy, "R8 abort forces idle", {cs_n, sclk, mosi, busy}, 8);
    repeat (20) @(negedge clk);
    chk(done_cnt == 0, "R8 no done after abort", done_cnt, 0);
    enable = 1'b1;
    @(negedge clk);
    run_txn(1, 2, 0, 1'b0);   // R7 flush before new exchange

    summary();
    $finish;
  end
endmodule